// File: doc/BRIEF.md
# Legacy Timer and Interrupt Status Logic

This block holds the timer and interrupt status state of a legacy sound-card bus interface. Software reaches it through a byte-wide decoded port interface: a 3-bit port number, a write strobe with a data byte, and a combinational read byte. Besides the plain registers it keeps a timer status byte and a shared interrupt status byte. Writes to the data and timer control ports set, mask and clear bits in both bytes as side effects.

Two up-counting timers run from a 1 µs tick input. A shared prescaler makes a base pulse every 80 ticks for the first timer, and every fourth such pulse drives the second timer (one every 320 ticks). Each timer reloads from its own count register and expires when it passes 0xFF. On expiry it raises status flags and, when enabled, interrupt flags. The interrupt output is a level that stays high while any interrupt status bit is set.

Top module: `legacy_timer_irq`

## Requirements
- R1: A read of port 0 returns the timer status byte when timer control bit 0 is 1, and the auxiliary status byte (written through port 3) when it is 0.
- R2: When the command register (written at port 0) holds 0x04 and timer control bit 0 is 0, a port 1 write with bit 7 set clears timer status bits 7, 6 and 5. A port 1 write with bit 7 clear loads the timer data register, which reads back at port 7.
- R3: Any other port 1 write stores the byte, which reads back at port 1. If timer control bit 1 is 1, the write also sets timer status bit 0 and forces the interrupt status byte (read at port 6) to 0x10.
- R4: A timer control write (port 2) with bit 5 at 0 clears timer status bits 4 and 3. With bit 1 at 0 it clears timer status bit 0. If timer status bits 0, 3 and 4 are then all 0, interrupt status bit 4 is cleared.
- R5: A timer control write with bit 2 at 0 clears timer status bit 2 and interrupt status bit 2. With bit 3 at 0 it clears timer status bit 1 and interrupt status bit 3.
- R6: Timer 1 runs while timer data bit 0 is 1 and timer 2 runs while timer data bit 1 is 1. Starting a timer loads its count register (port 4 for timer 1, port 5 for timer 2). It then increments on every 80-tick pulse (timer 1) or 320-tick pulse (timer 2), and expires and reloads when it steps past 0xFF. A stopped timer holds its count.
- R7: On timer 1 expiry, timer status bits 7 and 6 are set unless timer data bit 6 is 1. If timer control bit 2 is 1, timer status bit 2 and interrupt status bit 2 are also set.
- R8: On timer 2 expiry, timer status bits 7 and 5 are set unless timer data bit 5 is 1. If timer control bit 3 is 1, timer status bit 1 and interrupt status bit 3 are also set.
- R9: The irq output is high exactly when the interrupt status byte is nonzero. Reset clears every register, the prescaler and both timers.
- R10: Ports 2, 3, 4 and 5 read back the last byte written to them. Writes to ports 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| wr_en | input | 1 | Write strobe for the selected port |
| addr | input | 3 | Port number |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data of the selected port (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is a timer expiry that lands with both the flag and the interrupt paths armed. Software can only set this up indirectly: it programs a count near 0xFF, enables the interrupt bits while the status read still shows the auxiliary byte, starts the timer through the command 0x04 path, and then changes control bit 0 to see the result. The stimulus does exactly this for each timer, with and without the flag mask bits. A behavioural model tracks the prescaler phase, so the exact expiry cycle is compared every clock, not only after generous waits.

// File: rtl/lti_pkg.sv
package lti_pkg;
  localparam int BW = 8;

  typedef enum logic [2:0] {
    P_STAT  = 3'd0,
    P_DATA  = 3'd1,
    P_CTRL  = 3'd2,
    P_AUX   = 3'd3,
    P_CNT1  = 3'd4,
    P_CNT2  = 3'd5,
    P_IRQ   = 3'd6,
    P_TDATA = 3'd7
  } port_e;

  typedef struct packed {
    logic [BW-1:0] ts;
    logic [BW-1:0] is;
  } flags_t;

  // data-port write on the plain path while flagging is enabled
  function automatic flags_t data_flag(flags_t f);
    flags_t r = f;
    r.ts = r.ts | 8'h01;
    r.is = 8'h10;
    return r;
  endfunction

  // side effects of a timer control write with value c
  function automatic flags_t ctrl_clear(flags_t f, logic [BW-1:0] c);
    flags_t r = f;
    if (!c[5]) r.ts = r.ts & 8'hE7;
    if (!c[1]) r.ts = r.ts & 8'hFE;
    if ((r.ts & 8'h19) == 8'h00) r.is = r.is & 8'hEF;
    if (!c[2]) begin
      r.ts = r.ts & 8'hFB;
      r.is = r.is & 8'hFB;
    end
    if (!c[3]) begin
      r.ts = r.ts & 8'hFD;
      r.is = r.is & 8'hF7;
    end
    return r;
  endfunction

  function automatic flags_t t1_fire(flags_t f, logic [BW-1:0] td, logic [BW-1:0] c);
    flags_t r = f;
    if (!td[6]) r.ts = r.ts | 8'hC0;
    if (c[2]) begin
      r.ts = r.ts | 8'h04;
      r.is = r.is | 8'h04;
    end
    return r;
  endfunction

  function automatic flags_t t2_fire(flags_t f, logic [BW-1:0] td, logic [BW-1:0] c);
    flags_t r = f;
    if (!td[5]) r.ts = r.ts | 8'hA0;
    if (c[3]) begin
      r.ts = r.ts | 8'h02;
      r.is = r.is | 8'h08;
    end
    return r;
  endfunction
endpackage

// File: rtl/lti_prescale.sv
module lti_prescale #(
  parameter int T1_TICKS = 80,
  parameter int T2_MULT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  output logic pulse1,
  output logic pulse2
);
  localparam int W1 = (T1_TICKS > 1) ? $clog2(T1_TICKS) : 1;
  localparam int W2 = (T2_MULT > 1) ? $clog2(T2_MULT) : 1;
  localparam logic [W1-1:0] LAST1 = W1'(T1_TICKS - 1);
  localparam logic [W2-1:0] LAST2 = W2'(T2_MULT - 1);

  logic [W1-1:0] c1_q;
  logic [W2-1:0] c2_q;

  assign pulse1 = tick_us && (c1_q == LAST1);
  assign pulse2 = pulse1 && (c2_q == LAST2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_q <= '0;
      c2_q <= '0;
    end else begin
      if (tick_us) c1_q <= (c1_q == LAST1) ? '0 : c1_q + 1'b1;
      if (pulse1)  c2_q <= (c2_q == LAST2) ? '0 : c2_q + 1'b1;
    end
  end
endmodule

// File: rtl/lti_counter.sv
module lti_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         pulse,
  input  logic [W-1:0] reload,
  output logic [W-1:0] value,
  output logic         running,
  output logic         fire
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] v_q;
  logic         run_q;

  assign value   = v_q;
  assign running = run_q;
  assign fire    = start && run_q && pulse && (v_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= start;
      if (start && !run_q)  v_q <= reload;
      else if (start && pulse) v_q <= (v_q == TOP) ? reload : v_q + 1'b1;
    end
  end
endmodule

// File: rtl/lti_status.sv
module lti_status
  import lti_pkg::*;
#(
  parameter logic [BW-1:0] CMD_TIMER = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [BW-1:0] wdata,
  input  logic [1:0]    fire,
  output logic [BW-1:0] cmd_q,
  output logic [BW-1:0] ctrl_q,
  output logic [BW-1:0] aux_q,
  output logic [BW-1:0] dat_q,
  output logic [BW-1:0] td_q,
  output logic [BW-1:0] cnt1_q,
  output logic [BW-1:0] cnt2_q,
  output logic [BW-1:0] ts_q,
  output logic [BW-1:0] is_q
);
  flags_t        f_n;
  logic [BW-1:0] cmd_n, ctrl_n, aux_n, dat_n, td_n, cnt1_n, cnt2_n;
  logic          timer_path;

  assign timer_path = (cmd_q == CMD_TIMER) && !ctrl_q[0];

  always_comb begin
    f_n    = '{ts: ts_q, is: is_q};
    cmd_n  = cmd_q;
    ctrl_n = ctrl_q;
    aux_n  = aux_q;
    dat_n  = dat_q;
    td_n   = td_q;
    cnt1_n = cnt1_q;
    cnt2_n = cnt2_q;
    if (wr_en) begin
      case (addr)
        P_STAT: cmd_n = wdata;
        P_DATA: begin
          if (timer_path) begin
            if (wdata[7]) f_n.ts = f_n.ts & 8'h1F;
            else          td_n   = wdata;
          end else begin
            dat_n = wdata;
            if (ctrl_q[1]) f_n = data_flag(f_n);
          end
        end
        P_CTRL: begin
          ctrl_n = wdata;
          f_n    = ctrl_clear(f_n, wdata);
        end
        P_AUX:  aux_n  = wdata;
        P_CNT1: cnt1_n = wdata;
        P_CNT2: cnt2_n = wdata;
        default: ;
      endcase
    end
    if (fire[0]) f_n = t1_fire(f_n, td_q, ctrl_q);
    if (fire[1]) f_n = t2_fire(f_n, td_q, ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ctrl_q <= '0;
      aux_q  <= '0;
      dat_q  <= '0;
      td_q   <= '0;
      cnt1_q <= '0;
      cnt2_q <= '0;
      ts_q   <= '0;
      is_q   <= '0;
    end else begin
      cmd_q  <= cmd_n;
      ctrl_q <= ctrl_n;
      aux_q  <= aux_n;
      dat_q  <= dat_n;
      td_q   <= td_n;
      cnt1_q <= cnt1_n;
      cnt2_q <= cnt2_n;
      ts_q   <= f_n.ts;
      is_q   <= f_n.is;
    end
  end
endmodule

// File: rtl/legacy_timer_irq.sv
module legacy_timer_irq
  import lti_pkg::*;
#(
  parameter int            T1_TICKS  = 80,
  parameter int            T2_MULT   = 4,
  parameter logic [BW-1:0] CMD_TIMER = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          irq
);
  localparam int NT = 2;

  logic [BW-1:0] cmd_q, ctrl_q, aux_q, dat_q, td_q, cnt1_q, cnt2_q, ts_q, is_q;
  logic [NT-1:0] pulse, start, fire, running;
  logic [BW-1:0] reload [NT];
  logic [BW-1:0] tval   [NT];

  lti_prescale #(.T1_TICKS(T1_TICKS), .T2_MULT(T2_MULT)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
    .pulse1(pulse[0]), .pulse2(pulse[1])
  );

  assign start     = td_q[NT-1:0];
  assign reload[0] = cnt1_q;
  assign reload[1] = cnt2_q;

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    lti_counter #(.W(BW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start[i]), .pulse(pulse[i]),
      .reload(reload[i]), .value(tval[i]), .running(running[i]), .fire(fire[i])
    );
  end

  lti_status #(.CMD_TIMER(CMD_TIMER)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .fire(fire),
    .cmd_q(cmd_q), .ctrl_q(ctrl_q), .aux_q(aux_q), .dat_q(dat_q), .td_q(td_q),
    .cnt1_q(cnt1_q), .cnt2_q(cnt2_q), .ts_q(ts_q), .is_q(is_q)
  );

  always_comb begin
    case (addr)
      P_STAT:  rdata = ctrl_q[0] ? ts_q : aux_q;
      P_DATA:  rdata = dat_q;
      P_CTRL:  rdata = ctrl_q;
      P_AUX:   rdata = aux_q;
      P_CNT1:  rdata = cnt1_q;
      P_CNT2:  rdata = cnt2_q;
      P_IRQ:   rdata = is_q;
      default: rdata = td_q;
    endcase
  end

  assign irq = |is_q;
endmodule

// File: rtl/lti_checker.sv
module lti_checker
  import lti_pkg::*;
#(
  parameter logic [BW-1:0] CMD_TIMER = 8'h04
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    addr,
  input logic [BW-1:0] wdata,
  input logic [BW-1:0] cmd_q,
  input logic [BW-1:0] ctrl_q,
  input logic [BW-1:0] td_q,
  input logic [BW-1:0] ts_q,
  input logic [BW-1:0] is_q,
  input logic [1:0]    fire,
  input logic [BW-1:0] tval0
);
  logic wr_data, wr_ctrl, tpath;
  assign wr_data = wr_en && (addr == P_DATA);
  assign wr_ctrl = wr_en && (addr == P_CTRL);
  assign tpath   = (cmd_q == CMD_TIMER) && !ctrl_q[0];

  // R2
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tpath && wdata[7] && fire == 2'b00) |=> (ts_q[7:5] == 3'b000));

  // R3
  data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tpath && ctrl_q[1]) |=> (ts_q[0] && is_q[4]));

  // R4
  ctrl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[5] && !wdata[1]) |=> (!ts_q[0] && !is_q[4]));

  // R5
  ctrl_t1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[2] && !fire[0]) |=> (!ts_q[2] && !is_q[2]));

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!td_q[0]) |=> $stable(tval0));

  // R7
  t1_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[0] && !td_q[6]) |=> (ts_q[7] && ts_q[6]));

  // R8
  t2_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire[1] && ctrl_q[3]) |=> (ts_q[1] && is_q[3]));
endmodule

bind legacy_timer_irq lti_checker #(.CMD_TIMER(CMD_TIMER)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cmd_q(cmd_q), .ctrl_q(ctrl_q), .td_q(td_q), .ts_q(ts_q), .is_q(is_q),
  .fire(fire), .tval0(tval[0])
);

// File: tb/legacy_timer_irq_test.sv
module legacy_timer_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_us = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  legacy_timer_irq uut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference model
  int m_cmd, m_ctrl, m_aux, m_dat, m_td, m_c1, m_c2, m_ts, m_is;
  int pre1, pre2, v1, v2;
  bit run1, run2;

  function automatic int m_read(int a);
    case (a)
      0: return (m_ctrl % 2 == 1) ? m_ts : m_aux;
      1: return m_dat;
      2: return m_ctrl;
      3: return m_aux;
      4: return m_c1;
      5: return m_c2;
      6: return m_is;
      default: return m_td;
    endcase
  endfunction

  function automatic bit bitof(int v, int b);
    return ((v >> b) & 1) == 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmd = 0; m_ctrl = 0; m_aux = 0; m_dat = 0; m_td = 0;
      m_c1 = 0; m_c2 = 0; m_ts = 0; m_is = 0;
      pre1 = 0; pre2 = 0; v1 = 0; v2 = 0; run1 = 0; run2 = 0;
    end else begin
      bit p1, p2, s1, s2, f1, f2;
      int oc, otd, oc1, oc2;
      oc = m_ctrl; otd = m_td; oc1 = m_c1; oc2 = m_c2;
      s1 = bitof(otd, 0); s2 = bitof(otd, 1);
      p1 = tick_us && pre1 == 79;
      p2 = p1 && pre2 == 3;
      f1 = s1 && run1 && p1 && v1 == 255;
      f2 = s2 && run2 && p2 && v2 == 255;
      if (tick_us) pre1 = (pre1 == 79) ? 0 : pre1 + 1;
      if (p1) pre2 = (pre2 == 3) ? 0 : pre2 + 1;
      if (s1 && !run1) v1 = oc1; else if (s1 && p1) v1 = (v1 == 255) ? oc1 : v1 + 1;
      if (s2 && !run2) v2 = oc2; else if (s2 && p2) v2 = (v2 == 255) ? oc2 : v2 + 1;
      run1 = s1; run2 = s2;
      if (wr_en) begin
        case (int'(addr))
          0: m_cmd = wdata;
          1: if (m_cmd == 4 && !bitof(oc, 0)) begin
               if (wdata[7]) m_ts = m_ts & 8'h1F; else m_td = wdata;
             end else begin
               m_dat = wdata;
               if (bitof(oc, 1)) begin m_ts = m_ts | 1; m_is = 8'h10; end
             end
          2: begin
               m_ctrl = wdata;
               if (!wdata[5]) m_ts = m_ts & ~8'h18;
               if (!wdata[1]) m_ts = m_ts & ~8'h01;
               if ((m_ts & 8'h19) == 0) m_is = m_is & ~8'h10;
               if (!wdata[2]) begin m_ts = m_ts & ~4; m_is = m_is & ~4; end
               if (!wdata[3]) begin m_ts = m_ts & ~2; m_is = m_is & ~8; end
             end
          3: m_aux = wdata;
          4: m_c1 = wdata;
          5: m_c2 = wdata;
          default: ;
        endcase
      end
      if (f1) begin
        if (!bitof(otd, 6)) m_ts = m_ts | 8'hC0;
        if (bitof(oc, 2)) begin m_ts = m_ts | 4; m_is = m_is | 4; end
      end
      if (f2) begin
        if (!bitof(otd, 5)) m_ts = m_ts | 8'hA0;
        if (bitof(oc, 3)) begin m_ts = m_ts | 2; m_is = m_is | 8; end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model (covers R6 timing, R9 irq level)
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      check("R6/R10 model rdata", int'(rdata), m_read(int'(addr)));
      check("R9 model irq", int'(irq), (m_is != 0) ? 1 : 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 3'(a); wdata = 8'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int v;
    tick_us = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    rd(0, v); check("R9 reset status", v, 8'h00);
    rd(6, v); check("R9 reset irq byte", v, 8'h00);
    check("R9 reset irq pin", int'(irq), 0);
    // R1 read mux
    wr(3, 8'h5A);
    rd(0, v); check("R1 aux via status port", v, 8'h5A);
    wr(2, 8'h01);
    rd(0, v); check("R1 timer status via status port", v, 8'h00);
    // R3 plain data write with flagging
    wr(2, 8'h02); wr(0, 8'h11); wr(1, 8'h33);
    wr(2, 8'h03);
    rd(0, v); check("R3 status bit0", v, 8'h01);
    rd(6, v); check("R3 irq byte forced", v, 8'h10);
    check("R9 irq high", int'(irq), 1);
    rd(1, v); check("R3 data stored", v, 8'h33);
    // R4 control clears
    wr(2, 8'h01);
    rd(0, v); check("R4 status bit0 cleared", v, 8'h00);
    rd(6, v); check("R4 irq bit4 cleared", v, 8'h00);
    check("R9 irq low", int'(irq), 0);
    // R6/R7/R8 both timers with interrupts
    wr(4, 8'hFE); wr(5, 8'hFE); wr(2, 8'h0C); wr(0, 8'h04); wr(1, 8'h03);
    rd(7, v); check("R2 timer data loaded", v, 8'h03);
    wr(2, 8'h0D);
    repeat (200) @(negedge clk);
    rd(0, v); check("R7 timer1 flags", v, 8'hC4);
    rd(6, v); check("R7 timer1 irq bit", v, 8'h04);
    repeat (550) @(negedge clk);
    rd(0, v); check("R8 timer2 flags", v, 8'hE6);
    rd(6, v); check("R8 timer2 irq bit", v, 8'h0C);
    // R2 stop timers and clear bits 7..5
    wr(2, 8'h0C); wr(1, 8'h00); wr(1, 8'h80); wr(2, 8'h0D);
    rd(0, v); check("R2 bits 7..5 cleared", v, 8'h06);
    // R5 control clears of bits 2 and 1
    wr(2, 8'h09);
    rd(0, v); check("R5 status bit2 cleared", v, 8'h02);
    rd(6, v); check("R5 irq bit2 cleared", v, 8'h08);
    wr(2, 8'h01);
    rd(0, v); check("R5 status bit1 cleared", v, 8'h00);
    check("R5 irq pin low", int'(irq), 0);
    // R7 mask bit6
    wr(2, 8'h0C); wr(1, 8'h41);
    repeat (200) @(negedge clk);
    wr(2, 8'h0D);
    rd(0, v); check("R7 masked timer1", v, 8'h04);
    // R6 stop holds
    wr(2, 8'h0C); wr(1, 8'h00); wr(2, 8'h09);
    repeat (400) @(negedge clk);
    rd(0, v); check("R6 stopped timer no flags", v, 8'h00);
    rd(4, v); check("R10 count1 readback", v, 8'hFE);
    // R10 ignored writes
    wr(6, 8'hFF); wr(7, 8'hFF);
    rd(6, v); check("R10 irq byte unwritable", v, 8'h00);
    rd(7, v); check("R10 timer data unwritable", v, 8'h00);
    // R8 mask bit5
    wr(2, 8'h08); wr(1, 8'h22);
    repeat (700) @(negedge clk);
    wr(2, 8'h09);
    rd(0, v); check("R8 masked timer2", v, 8'h02);
    rd(6, v); check("R8 timer2 irq only", v, 8'h08);
    finish_run();
  end
endmodule